// File: doc/BRIEF.md
# FEC Decoder Statistics Collector

This block sits beside a Reed-Solomon decoder whose symbols are 10 bits wide. On each beat it receives a group of symbols as they arrived at the decoder and the same symbols as the decoder emits them. A last-beat strobe marks the end of each codeword, and the decoder's uncorrectable flag is valid on that last beat. The block compares the two versions bit by bit. When a codeword ends, it folds the codeword's totals into a bank of saturating counters:

- codewords processed, corrected and uncorrected;
- errored symbols;
- bits repaired from one to zero, from zero to one, and in total;
- a histogram of codewords by errored-symbol count.

Each counter exists twice. One copy is cumulative since reset. The other runs over an interval: a tick pulse copies it into a snapshot register and restarts it from zero. A host reads either copy through a simple combinational read port. The correction limit t is 15 when the wide code is selected and 7 when the narrow code is selected.

Top module: `fec_stat_collector`

## Requirements
- R1: Counter 4 counts the bits of non-flagged codewords that were 1 before decoding and 0 after.
- R2: Counter 5 counts the bits of non-flagged codewords that were 0 before decoding and 1 after.
- R3: Counter 6 equals the sum of counters 4 and 5 unless saturation intervenes.
- R4: Counter 0 increments by exactly one for every codeword, whatever its outcome. A codeword ends on a beat with `beat_valid` and `cw_end` both high.
- R5: Counter 1 counts codewords with between 1 and t errored symbols. Counter 2 counts codewords that are flagged by `cw_uncorr`, or whose errored-symbol count exceeds t.
- R6: `mode_kp`, sampled on the last beat, sets t: 1 selects t = 15 and 0 selects t = 7.
- R7: Counter 3 adds, for each correctable codeword, the number of 10-bit symbols that differ anywhere between the two versions. Symbol lane i occupies bits [10i+9:10i].
- R8: An uncorrectable codeword adds nothing to counters 1, 3, 4, 5, 6 or to bins 0 to 15. It increments overflow bin counter 23.
- R9: A correctable codeword with n errored symbols increments bin counter 7+n, for n from 0 to 15. A codeword with no errors touches only counter 0 and bin counter 7.
- R10: A one-cycle `interval_tick` copies every interval counter into its snapshot and clears it in the same cycle. An increment applied in that cycle lands in the snapshot, and no increment is lost.
- R11: Every counter saturates at all ones (CNT_W bits, 48 by default) instead of wrapping.
- R12: `rd_data` shows counter `rd_sel` from the cumulative set when `rd_cum`=1 and from the snapshot set when `rd_cum`=0. It is 0 for any index of 24 or more. Counters reflect a codeword two clock edges after its last beat is sampled.
- R13: After a synchronous reset all counters and snapshots read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_kp | input | 1 | 1: t = 15, 0: t = 7 |
| beat_valid | input | 1 | Symbol group valid this cycle |
| pre_syms | input | NSYM*10 | Symbols before correction, lane i at bits [10i+9:10i] |
| post_syms | input | NSYM*10 | Symbols after correction, same layout |
| cw_end | input | 1 | Beat is the last of a codeword |
| cw_uncorr | input | 1 | Decoder found the codeword uncorrectable (last beat) |
| interval_tick | input | 1 | Interval boundary pulse |
| rd_sel | input | 5 | Counter index |
| rd_cum | input | 1 | 1: cumulative set, 0: snapshot set |
| rd_data | output | CNT_W | Selected counter value |

## Verification
The delicate coincidence is an interval tick arriving in the same cycle that a finished codeword's increments reach the counters. The bench provokes this by raising the tick one cycle after the codeword's last beat, so the increments must appear in the snapshot and the new interval must start empty. The bench also provokes the neighbouring case, with the tick on the last beat itself, where the increments must instead land in the fresh interval. Both cases are judged by reading every snapshot and cumulative counter through the port and comparing them with a model that applies commit and tick in the order the requirements dictate.

// File: rtl/fec_stat_pkg.sv
package fec_stat_pkg;

    localparam int SYM_W   = 10;
    localparam int T_KP    = 15;
    localparam int T_KR    = 7;
    localparam int ACC_W   = 16;
    localparam int SCNT_W  = 10;

    localparam int CTR_PROC      = 0;
    localparam int CTR_CORR_CW   = 1;
    localparam int CTR_UNCORR_CW = 2;
    localparam int CTR_SYM_ERR   = 3;
    localparam int CTR_ONES      = 4;
    localparam int CTR_ZEROS     = 5;
    localparam int CTR_BITS      = 6;
    localparam int N_FIXED       = 7;
    localparam int N_BINS        = T_KP + 2;
    localparam int N_CTR         = N_FIXED + N_BINS;
    localparam int CTR_OVF       = N_CTR - 1;

    typedef enum logic {
        BANK_SNAP = 1'b0,
        BANK_CUM  = 1'b1
    } bank_e;

    typedef struct packed {
        logic              valid;
        logic              bad;
        logic [ACC_W-1:0]  ones;
        logic [ACC_W-1:0]  zeros;
        logic [SCNT_W-1:0] syms;
    } cw_stat_t;

    function automatic logic [3:0] pop_sym(input logic [SYM_W-1:0] v);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < SYM_W; i++) begin
            n = n + 4'(v[i]);
        end
        return n;
    endfunction

    function automatic logic [SCNT_W-1:0] t_limit(input logic kp);
        return kp ? SCNT_W'(T_KP) : SCNT_W'(T_KR);
    endfunction

endpackage

// File: rtl/fec_stat_symcmp.sv
module fec_stat_symcmp
    import fec_stat_pkg::*;
#(
    parameter int NSYM = 4,
    localparam int DATA_W = NSYM * SYM_W
) (
    input  logic [DATA_W-1:0] pre_syms,
    input  logic [DATA_W-1:0] post_syms,
    output logic [ACC_W-1:0]  beat_ones,
    output logic [ACC_W-1:0]  beat_zeros,
    output logic [SCNT_W-1:0] beat_syms
);

    logic [NSYM-1:0][3:0] lane_ones;
    logic [NSYM-1:0][3:0] lane_zeros;
    logic [NSYM-1:0]      lane_err;

    for (genvar g = 0; g < NSYM; g++) begin : g_lane
        logic [SYM_W-1:0] p_s;
        logic [SYM_W-1:0] q_s;
        assign p_s           = pre_syms[g*SYM_W +: SYM_W];
        assign q_s           = post_syms[g*SYM_W +: SYM_W];
        assign lane_ones[g]  = pop_sym(p_s & ~q_s);
        assign lane_zeros[g] = pop_sym(~p_s & q_s);
        assign lane_err[g]   = |(p_s ^ q_s);
    end

    always_comb begin
        beat_ones  = '0;
        beat_zeros = '0;
        beat_syms  = '0;
        for (int i = 0; i < NSYM; i++) begin
            beat_ones  = beat_ones + ACC_W'(lane_ones[i]);
            beat_zeros = beat_zeros + ACC_W'(lane_zeros[i]);
            beat_syms  = beat_syms + SCNT_W'(lane_err[i]);
        end
    end

endmodule

// File: rtl/fec_stat_cwacc.sv
module fec_stat_cwacc
    import fec_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_valid,
    input  logic              cw_end,
    input  logic              cw_uncorr,
    input  logic              mode_kp,
    input  logic [ACC_W-1:0]  beat_ones,
    input  logic [ACC_W-1:0]  beat_zeros,
    input  logic [SCNT_W-1:0] beat_syms,
    output cw_stat_t          commit_q
);

    logic [ACC_W-1:0]  run_ones;
    logic [ACC_W-1:0]  run_zeros;
    logic [SCNT_W-1:0] run_syms;
    logic [ACC_W-1:0]  sum_ones;
    logic [ACC_W-1:0]  sum_zeros;
    logic [SCNT_W-1:0] sum_syms;
    logic              cw_bad;

    always_comb begin
        sum_ones  = run_ones + beat_ones;
        sum_zeros = run_zeros + beat_zeros;
        sum_syms  = run_syms + beat_syms;
        cw_bad    = cw_uncorr || (sum_syms > t_limit(mode_kp));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_ones  <= '0;
            run_zeros <= '0;
            run_syms  <= '0;
        end else if (beat_valid) begin
            if (cw_end) begin
                run_ones  <= '0;
                run_zeros <= '0;
                run_syms  <= '0;
            end else begin
                run_ones  <= sum_ones;
                run_zeros <= sum_zeros;
                run_syms  <= sum_syms;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_q <= '0;
        end else begin
            commit_q.valid <= beat_valid && cw_end;
            commit_q.bad   <= cw_bad;
            commit_q.ones  <= sum_ones;
            commit_q.zeros <= sum_zeros;
            commit_q.syms  <= sum_syms;
        end
    end

endmodule

// File: rtl/fec_stat_ctr.sv
module fec_stat_ctr #(
    parameter int CNT_W = 48,
    parameter int INC_W = 17,
    localparam int SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INC_W-1:0] inc,
    input  logic             tick,
    output logic [CNT_W-1:0] cum_q,
    output logic [CNT_W-1:0] ivl_q,
    output logic [CNT_W-1:0] shd_q
);

    localparam logic [SUM_W-1:0] CAP = SUM_W'({CNT_W{1'b1}});

    logic [SUM_W-1:0] cum_sum;
    logic [SUM_W-1:0] ivl_sum;
    logic [CNT_W-1:0] cum_nxt;
    logic [CNT_W-1:0] ivl_nxt;

    always_comb begin
        cum_sum = SUM_W'(cum_q) + SUM_W'(inc);
        ivl_sum = SUM_W'(ivl_q) + SUM_W'(inc);
        cum_nxt = (cum_sum > CAP) ? CAP[CNT_W-1:0] : cum_sum[CNT_W-1:0];
        ivl_nxt = (ivl_sum > CAP) ? CAP[CNT_W-1:0] : ivl_sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cum_q <= '0;
            ivl_q <= '0;
            shd_q <= '0;
        end else begin
            cum_q <= cum_nxt;
            if (tick) begin
                shd_q <= ivl_nxt;
                ivl_q <= '0;
            end else begin
                ivl_q <= ivl_nxt;
            end
        end
    end

endmodule

// File: rtl/fec_stat_collector.sv
module fec_stat_collector
    import fec_stat_pkg::*;
#(
    parameter int NSYM  = 4,
    parameter int CNT_W = 48,
    localparam int DATA_W = NSYM * SYM_W,
    localparam int RD_W   = $clog2(N_CTR)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_kp,
    input  logic              beat_valid,
    input  logic [DATA_W-1:0] pre_syms,
    input  logic [DATA_W-1:0] post_syms,
    input  logic              cw_end,
    input  logic              cw_uncorr,
    input  logic              interval_tick,
    input  logic [RD_W-1:0]   rd_sel,
    input  logic              rd_cum,
    output logic [CNT_W-1:0]  rd_data
);

    localparam int INC_W = ACC_W + 1;

    logic [ACC_W-1:0]  beat_ones;
    logic [ACC_W-1:0]  beat_zeros;
    logic [SCNT_W-1:0] beat_syms;
    cw_stat_t          commit_q;
    logic              cw_good;
    bank_e             rd_bank;

    logic [N_CTR-1:0][INC_W-1:0] inc;
    logic [N_CTR-1:0][CNT_W-1:0] cum_q;
    logic [N_CTR-1:0][CNT_W-1:0] ivl_q;
    logic [N_CTR-1:0][CNT_W-1:0] shd_q;

    fec_stat_symcmp #(.NSYM(NSYM)) i_symcmp (
        .pre_syms   (pre_syms),
        .post_syms  (post_syms),
        .beat_ones  (beat_ones),
        .beat_zeros (beat_zeros),
        .beat_syms  (beat_syms)
    );

    fec_stat_cwacc i_cwacc (
        .clk        (clk),
        .rst        (rst),
        .beat_valid (beat_valid),
        .cw_end     (cw_end),
        .cw_uncorr  (cw_uncorr),
        .mode_kp    (mode_kp),
        .beat_ones  (beat_ones),
        .beat_zeros (beat_zeros),
        .beat_syms  (beat_syms),
        .commit_q   (commit_q)
    );

    always_comb begin
        inc     = '0;
        cw_good = commit_q.valid && !commit_q.bad;
        inc[CTR_PROC]      = INC_W'(commit_q.valid);
        inc[CTR_UNCORR_CW] = INC_W'(commit_q.valid && commit_q.bad);
        inc[CTR_OVF]       = INC_W'(commit_q.valid && commit_q.bad);
        inc[CTR_CORR_CW]   = INC_W'(cw_good && (commit_q.syms != '0));
        if (cw_good) begin
            inc[CTR_SYM_ERR] = INC_W'(commit_q.syms);
            inc[CTR_ONES]    = INC_W'(commit_q.ones);
            inc[CTR_ZEROS]   = INC_W'(commit_q.zeros);
            inc[CTR_BITS]    = INC_W'(commit_q.ones) + INC_W'(commit_q.zeros);
        end
        for (int b = 0; b <= T_KP; b++) begin
            inc[N_FIXED + b] = INC_W'(cw_good && (commit_q.syms == SCNT_W'(b)));
        end
    end

    for (genvar c = 0; c < N_CTR; c++) begin : g_ctr
        fec_stat_ctr #(.CNT_W(CNT_W), .INC_W(INC_W)) i_ctr (
            .clk   (clk),
            .rst   (rst),
            .inc   (inc[c]),
            .tick  (interval_tick),
            .cum_q (cum_q[c]),
            .ivl_q (ivl_q[c]),
            .shd_q (shd_q[c])
        );
    end

    assign rd_bank = bank_e'(rd_cum);

    always_comb begin
        rd_data = '0;
        if (int'(rd_sel) < N_CTR) begin
            rd_data = (rd_bank == BANK_CUM) ? cum_q[rd_sel] : shd_q[rd_sel];
        end
    end

endmodule

// File: rtl/fec_stat_checker.sv
module fec_stat_checker
    import fec_stat_pkg::*;
#(
    parameter int NCTR  = N_CTR,
    parameter int CNT_W = 48,
    parameter int RD_W  = 5
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       beat_valid,
    input logic                       cw_end,
    input logic                       interval_tick,
    input logic [RD_W-1:0]            rd_sel,
    input logic [CNT_W-1:0]           rd_data,
    input logic [NCTR-1:0][CNT_W-1:0] cum_q,
    input logic [NCTR-1:0][CNT_W-1:0] ivl_q,
    input logic [NCTR-1:0][CNT_W-1:0] shd_q
);

    localparam logic [CNT_W+1:0] MAXV = {2'b00, {CNT_W{1'b1}}};
    localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

    logic [CNT_W+1:0] bit_sum;
    logic [CNT_W+1:0] split_sum;

    assign bit_sum   = {2'b00, cum_q[CTR_ONES]} + {2'b00, cum_q[CTR_ZEROS]};
    assign split_sum = {2'b00, cum_q[CTR_CORR_CW]} + {2'b00, cum_q[CTR_UNCORR_CW]}
                     + {2'b00, cum_q[N_FIXED]};

    AST_BITS_SUM: assert property (@(posedge clk) disable iff (rst)
        (bit_sum < MAXV) |-> ({2'b00, cum_q[CTR_BITS]} == bit_sum)); // R3

    AST_PROC_SPLIT: assert property (@(posedge clk) disable iff (rst)
        ({2'b00, cum_q[CTR_PROC]} < MAXV) |-> (split_sum == {2'b00, cum_q[CTR_PROC]})); // R4

    AST_PROC_STEP: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && cw_end) |-> ##2 ((cum_q[CTR_PROC] == $past(cum_q[CTR_PROC]) + 1'b1)
                                        || ($past(cum_q[CTR_PROC]) == ALL1))); // R4

    for (genvar i = 0; i < NCTR; i++) begin : g_mono
        AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
            cum_q[i] >= $past(cum_q[i])); // R11
    end

    AST_TICK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        interval_tick |=> (ivl_q == '0)); // R10

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !interval_tick |=> $stable(shd_q)); // R10

    AST_RD_RANGE: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_sel) >= NCTR) |-> (rd_data == '0)); // R12

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> ((cum_q == '0) && (ivl_q == '0) && (shd_q == '0))); // R13

endmodule

bind fec_stat_collector fec_stat_checker #(
    .NCTR  (fec_stat_pkg::N_CTR),
    .CNT_W (CNT_W),
    .RD_W  (RD_W)
) i_fec_stat_checker (
    .clk           (clk),
    .rst           (rst),
    .beat_valid    (beat_valid),
    .cw_end        (cw_end),
    .interval_tick (interval_tick),
    .rd_sel        (rd_sel),
    .rd_data       (rd_data),
    .cum_q         (cum_q),
    .ivl_q         (ivl_q),
    .shd_q         (shd_q)
);

// File: tb/test_fec_stat_collector.sv
module test_fec_stat_collector;
    import fec_stat_pkg::*;

    localparam int NSYM   = 4;
    localparam int CNT_W  = 12;
    localparam int DATA_W = NSYM * SYM_W;
    localparam longint MAXV = (64'd1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mode_kp = 1'b1;
    logic              beat_valid = 1'b0;
    logic [DATA_W-1:0] pre_syms = '0;
    logic [DATA_W-1:0] post_syms = '0;
    logic              cw_end = 1'b0;
    logic              cw_uncorr = 1'b0;
    logic              interval_tick = 1'b0;
    logic [4:0]        rd_sel = '0;
    logic              rd_cum = 1'b1;
    logic [CNT_W-1:0]  rd_data;

    longint cum_m[N_CTR];
    longint ivl_m[N_CTR];
    longint shd_m[N_CTR];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fec_stat_collector #(.NSYM(NSYM), .CNT_W(CNT_W)) i_fec_stat_collector (
        .clk           (clk),
        .rst           (rst),
        .mode_kp       (mode_kp),
        .beat_valid    (beat_valid),
        .pre_syms      (pre_syms),
        .post_syms     (post_syms),
        .cw_end        (cw_end),
        .cw_uncorr     (cw_uncorr),
        .interval_tick (interval_tick),
        .rd_sel        (rd_sel),
        .rd_cum        (rd_cum),
        .rd_data       (rd_data)
    );

    function automatic string ctr_req(int i);
        if (i == 0) return "R4";
        if (i == 1 || i == 2) return "R5";
        if (i == 3) return "R7";
        if (i == 4) return "R1";
        if (i == 5) return "R2";
        if (i == 6) return "R3";
        if (i == 23) return "R8";
        return "R9";
    endfunction

    function automatic longint sat(longint a, longint b);
        return (a + b > MAXV) ? MAXV : a + b;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < N_CTR; i++) begin
            cum_m[i] = 0;
            ivl_m[i] = 0;
            shd_m[i] = 0;
        end
    endtask

    task automatic model_add(int i, longint v);
        cum_m[i] = sat(cum_m[i], v);
        ivl_m[i] = sat(ivl_m[i], v);
    endtask

    task automatic model_commit(int ones, int zeros, int syms, bit bad);
        model_add(0, 1);
        if (bad) begin
            model_add(2, 1);
            model_add(23, 1);
        end else begin
            if (syms > 0) model_add(1, 1);
            model_add(3, syms);
            model_add(4, ones);
            model_add(5, zeros);
            model_add(6, ones + zeros);
            model_add(7 + syms, 1);
        end
    endtask

    task automatic model_tick();
        for (int i = 0; i < N_CTR; i++) begin
            shd_m[i] = ivl_m[i];
            ivl_m[i] = 0;
        end
    endtask

    // tick_mode 0: no tick, 1: tick on the last beat, 2: tick one cycle later
    task automatic send_cw(int nbeats, int nerr, logic [9:0] pre_v, logic [9:0] flip,
                           bit unc, bit kp, int tick_mode);
        int ones;
        int zeros;
        bit bad;
        for (int b = 0; b < nbeats; b++) begin
            @(negedge clk);
            for (int l = 0; l < NSYM; l++) begin
                pre_syms[l*SYM_W +: SYM_W]  = pre_v;
                post_syms[l*SYM_W +: SYM_W] = (b*NSYM + l < nerr) ? (pre_v ^ flip) : pre_v;
            end
            beat_valid    = 1'b1;
            mode_kp       = kp;
            cw_end        = (b == nbeats - 1);
            cw_uncorr     = unc && (b == nbeats - 1);
            interval_tick = (tick_mode == 1) && (b == nbeats - 1);
        end
        @(negedge clk);
        beat_valid    = 1'b0;
        cw_end        = 1'b0;
        cw_uncorr     = 1'b0;
        interval_tick = (tick_mode == 2);
        if (tick_mode == 2) begin
            @(negedge clk);
            interval_tick = 1'b0;
        end
        ones  = nerr * $countones(pre_v & flip);
        zeros = nerr * $countones(~pre_v & flip);
        bad   = unc || (nerr > (kp ? 15 : 7));
        if (tick_mode == 1) model_tick();
        model_commit(ones, zeros, nerr, bad);
        if (tick_mode == 2) model_tick();
    endtask

    task automatic check_ctr(int i, bit cum, string tag);
        longint exp;
        rd_sel = 5'(i);
        rd_cum = cum;
        #0.5;
        exp = (i >= N_CTR) ? 0 : (cum ? cum_m[i] : shd_m[i]);
        checks++;
        if (rd_data !== exp[CNT_W-1:0]) begin
            errors++;
            $display("FAIL %s/%s ctr %0d bank %0d: got %0d expected %0d",
                     tag, (i >= N_CTR) ? "R12" : ctr_req(i), i, cum, rd_data, exp);
        end
    endtask

    task automatic check_all(string tag);
        repeat (2) @(negedge clk);
        for (int i = 0; i < N_CTR; i++) begin
            check_ctr(i, 1'b1, tag);
            check_ctr(i, 1'b0, tag);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        model_clear();
        check_all("R13 reset");
    endtask

    task automatic t_clean();
        send_cw(3, 0, 10'h155, 10'h000, 1'b0, 1'b1, 0);
        check_all("R4 R9 clean");
    endtask

    task automatic t_correct();
        send_cw(2, 5, 10'h3F0, 10'h0FF, 1'b0, 1'b1, 0);
        check_all("R1 R2 R3 R5 R7 corrected");
        send_cw(1, 1, 10'h000, 10'h201, 1'b0, 1'b1, 0);
        check_all("R2 R7 single");
    endtask

    task automatic t_mode();
        send_cw(2, 8, 10'h2AA, 10'h3FF, 1'b0, 1'b0, 0);
        check_all("R6 narrow over t");
        send_cw(2, 8, 10'h2AA, 10'h3FF, 1'b0, 1'b1, 0);
        check_all("R6 wide 8");
        send_cw(2, 7, 10'h0C3, 10'h111, 1'b0, 1'b0, 0);
        check_all("R6 narrow at t");
        send_cw(4, 16, 10'h2AA, 10'h00F, 1'b0, 1'b1, 0);
        check_all("R6 wide over t");
        send_cw(4, 15, 10'h2AA, 10'h00F, 1'b0, 1'b1, 0);
        check_all("R6 wide at t");
    endtask

    task automatic t_flag();
        send_cw(2, 3, 10'h0F0, 10'h0FF, 1'b1, 1'b1, 0);
        check_all("R8 flagged");
    endtask

    task automatic t_interval();
        send_cw(1, 2, 10'h3C3, 10'h0F0, 1'b0, 1'b1, 1);
        check_all("R10 tick on last beat");
        send_cw(1, 3, 10'h3C3, 10'h0F0, 1'b0, 1'b1, 2);
        check_all("R10 tick with update");
        @(negedge clk);
        interval_tick = 1'b1;
        @(negedge clk);
        interval_tick = 1'b0;
        model_tick();
        check_all("R10 idle tick");
    endtask

    task automatic t_back_to_back();
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            for (int l = 0; l < NSYM; l++) begin
                pre_syms[l*SYM_W +: SYM_W]  = 10'(k * 37);
                post_syms[l*SYM_W +: SYM_W] = (l < k) ? (10'(k * 37) ^ 10'h081) : 10'(k * 37);
            end
            beat_valid = 1'b1;
            cw_end     = 1'b1;
            cw_uncorr  = (k == 3);
            mode_kp    = 1'b0;
            model_commit(k * $countones(10'(k * 37) & 10'h081),
                         k * $countones(~10'(k * 37) & 10'h081), k, k == 3);
        end
        @(negedge clk);
        beat_valid = 1'b0;
        cw_end     = 1'b0;
        cw_uncorr  = 1'b0;
        check_all("R4 back-to-back");
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 110; k++) begin
            send_cw(1, 4, 10'h3FF, 10'h3FF, 1'b0, 1'b1, 0);
        end
        check_all("R11 saturate");
    endtask

    task automatic t_range();
        @(negedge clk);
        for (int i = N_CTR; i < 32; i++) begin
            check_ctr(i, 1'b1, "R12 range");
            check_ctr(i, 1'b0, "R12 range");
        end
    endtask

    initial begin
        model_clear();
        t_reset();
        t_clean();
        t_correct();
        t_mode();
        t_flag();
        t_interval();
        t_back_to_back();
        t_saturate();
        t_range();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule